// File: doc/BRIEF.md
# Serial-Bus Transceiver Mode Controller

This block is a small slave that a host reaches through a handful of general-purpose pins. The bus has an active-low chip select, a read/write select, a host-driven serial clock, a 3-bit register address, a serial data line into the slave and a serial data line back to the host. Behind the bus sit four channel configuration registers. Each register chooses the line standard (RS232 or RS485), the duplex mode and whether the receiver is muted while the channel transmits. From these settings and each channel's RTS (transmit-active) input, the block drives the channel's line-driver enable, receiver enable and two mode-select pins.

The slave runs on its own system clock and oversamples the host clock and chip select through a synchronizer. A frame state machine has three states. `ST_IDLE` waits for chip select. `ST_SHIFT` counts eight data bits. `ST_HOLD` waits for chip select to be released after a full byte. The transitions are as follows. `ST_IDLE` to `ST_SHIFT` happens on chip select assertion, and at that point the address and direction are latched and the read byte is preloaded. `ST_SHIFT` to `ST_HOLD` happens on the eighth rising host clock. `ST_SHIFT` to `ST_IDLE` happens on early release, and the frame is abandoned. `ST_HOLD` to `ST_IDLE` happens on release, and a write is committed on that cycle.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: After reset every register is 0. All channels then show RS232, full duplex, receiver enabled and driver enabled, and `sb_miso` is 0.
- R2: A frame with `sb_rd`=0 carries 8 bits MSB first on `sb_mosi`, sampled on rising `sb_sck` while `sb_cs_n` is low. On release of `sb_cs_n` the low 3 bits are stored in the register at `sb_addr` (0 to 3). In the stored value, bit 0 means RS485 when 1, bit 1 means half duplex when 1 and bit 2 means echo-inhibit when 1.
- R3: A frame with `sb_rd`=1 returns the addressed register on `sb_miso` as 8 bits MSB first. The first bit is valid before the first rising `sb_sck`, and the line advances after each falling `sb_sck`. `sb_miso` is 0 between frames.
- R4: A write frame released before its eighth rising clock leaves every register unchanged.
- R5: Writes to addresses 4 to 7 change no register, and reads from them return 0x00.
- R6: Written bits 7 to 3 are discarded and read back as 0.
- R7: In RS485 mode `ch_drv_en` equals that channel's `ch_rts`. In RS232 mode `ch_drv_en` is 1.
- R8: `ch_rx_en` is 0 exactly when the channel's echo-inhibit bit is 1 and its `ch_rts` is 1. The other mode bits have no effect on it.
- R9: `ch_rs485` shows register bit 0 and `ch_hdx` shows register bit 1 of the same channel.
- R10: A write to one channel leaves the other channels' registers unchanged.
- R11: Host clock edges after the eighth within one frame are ignored, so the first eight bits decide the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sb_cs_n | input | 1 | Bus chip select, active low, frames a transfer |
| sb_rd | input | 1 | 1 read, 0 write |
| sb_sck | input | 1 | Host serial clock, idles low |
| sb_addr | input | 3 | Register address |
| sb_mosi | input | 1 | Serial data from host |
| sb_miso | output | 1 | Serial data to host |
| ch_rts | input | 4 | Per-channel transmit-active (RTS) |
| ch_drv_en | output | 4 | Per-channel line-driver enable |
| ch_rx_en | output | 4 | Per-channel receiver enable |
| ch_rs485 | output | 4 | Per-channel line-standard select, 1 = RS485 |
| ch_hdx | output | 4 | Per-channel duplex select, 1 = half duplex |

## Verification
The channel outputs are combinational in the registers and `ch_rts`, so they are due in the same cycle as an RTS change. The bench samples them one clock after it drives RTS. A write lands on the third rising system clock after `sb_cs_n` goes high, which is two synchronizer stages plus the register. `sb_miso` advances three system clocks after a falling `sb_sck`. The bench holds every host-clock half period for ten system clocks and waits twenty after each release, so every readback and mode-pin check falls well after its due cycle.

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;

    typedef struct packed {
        logic echo_inh;   // bit 2
        logic half_dx;    // bit 1
        logic rs485;      // bit 0
    } chan_cfg_t;

    localparam int CFG_W = $bits(chan_cfg_t);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } frame_st_t;

endpackage

// File: rtl/xmc_sync.sv
module xmc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_in,
    input  logic sck_in,
    output logic cs_act,
    output logic sck_rise,
    output logic sck_fall
);
    logic [STAGES-1:0] cs_pipe;
    logic [STAGES-1:0] sck_pipe;
    logic              sck_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_pipe  <= '1;
            sck_pipe <= '0;
            sck_last <= 1'b0;
        end else begin
            cs_pipe  <= {cs_pipe[STAGES-2:0], cs_n_in};
            sck_pipe <= {sck_pipe[STAGES-2:0], sck_in};
            sck_last <= sck_pipe[STAGES-1];
        end
    end

    assign cs_act   = ~cs_pipe[STAGES-1];
    assign sck_rise =  sck_pipe[STAGES-1] & ~sck_last;
    assign sck_fall = ~sck_pipe[STAGES-1] &  sck_last;
endmodule

// File: rtl/xmc_frame_fsm.sv
module xmc_frame_fsm
    import xcvr_mode_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sb_rd,
    input  logic [ADDR_W-1:0] sb_addr,
    input  logic              sb_mosi,
    input  logic [CFG_W-1:0]  rd_cfg,
    output logic              sb_miso,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [CFG_W-1:0]  wr_cfg
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    frame_st_t         st_q, st_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_q;
    logic [CFG_W-1:0]  rx_sr;
    logic [DATA_W-1:0] tx_sr;

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (cs_act) st_d = ST_SHIFT;
            ST_SHIFT: begin
                if (!cs_act)
                    st_d = ST_IDLE;
                else if (sck_rise && cnt_q == CNT_W'(DATA_W - 1))
                    st_d = ST_HOLD;
            end
            ST_HOLD:  if (!cs_act) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // state register and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            addr_q <= '0;
            rd_q   <= 1'b0;
            rx_sr  <= '0;
            tx_sr  <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && cs_act) begin
                addr_q <= sb_addr;
                rd_q   <= sb_rd;
                cnt_q  <= '0;
                tx_sr  <= DATA_W'(rd_cfg);
            end
            if (st_q == ST_SHIFT && cs_act) begin
                if (sck_rise) begin
                    rx_sr <= {rx_sr[CFG_W-2:0], sb_mosi};
                    cnt_q <= cnt_q + CNT_W'(1);
                end
                if (sck_fall)
                    tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        sb_miso = (st_q != ST_IDLE) & tx_sr[DATA_W-1];
        wr_stb  = (st_q == ST_HOLD) & ~cs_act & ~rd_q;
        wr_addr = addr_q;
        wr_cfg  = rx_sr;
    end
endmodule

// File: rtl/xmc_cfg_bank.sv
module xmc_cfg_bank
    import xcvr_mode_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int ADDR_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_stb,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [CFG_W-1:0]      wr_cfg,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [CFG_W-1:0]      rd_cfg,
    output chan_cfg_t [N_CH-1:0]  cfg_q
);
    for (genvar c = 0; c < N_CH; c++) begin : g_reg
        chan_cfg_t r_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                r_q <= '0;
            else if (wr_stb && wr_addr == ADDR_W'(c))
                r_q <= chan_cfg_t'(wr_cfg);
        end
        assign cfg_q[c] = r_q;
    end

    always_comb begin
        rd_cfg = '0;
        for (int c = 0; c < N_CH; c++)
            if (rd_addr == ADDR_W'(c))
                rd_cfg = cfg_q[c];
    end
endmodule

// File: rtl/xmc_line_ctrl.sv
module xmc_line_ctrl
    import xcvr_mode_pkg::*;
(
    input  chan_cfg_t cfg,
    input  logic      rts,
    output logic      drv_en,
    output logic      rx_en,
    output logic      sel_rs485,
    output logic      sel_hdx
);
    always_comb begin
        drv_en    = cfg.rs485 ? rts : 1'b1;
        rx_en     = ~(cfg.echo_inh & rts);
        sel_rs485 = cfg.rs485;
        sel_hdx   = cfg.half_dx;
    end
endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
    import xcvr_mode_pkg::*;
#(
    parameter int N_CH        = 4,
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sb_cs_n,
    input  logic              sb_rd,
    input  logic              sb_sck,
    input  logic [ADDR_W-1:0] sb_addr,
    input  logic              sb_mosi,
    output logic              sb_miso,
    input  logic [N_CH-1:0]   ch_rts,
    output logic [N_CH-1:0]   ch_drv_en,
    output logic [N_CH-1:0]   ch_rx_en,
    output logic [N_CH-1:0]   ch_rs485,
    output logic [N_CH-1:0]   ch_hdx
);
    logic                 cs_act, sck_rise, sck_fall;
    logic                 wr_stb;
    logic [ADDR_W-1:0]    wr_addr;
    logic [CFG_W-1:0]     wr_cfg, rd_cfg;
    chan_cfg_t [N_CH-1:0] cfg_q;

    xmc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .cs_n_in(sb_cs_n), .sck_in(sb_sck),
        .cs_act(cs_act), .sck_rise(sck_rise), .sck_fall(sck_fall)
    );

    xmc_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cs_act(cs_act), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .sb_rd(sb_rd), .sb_addr(sb_addr), .sb_mosi(sb_mosi),
        .rd_cfg(rd_cfg), .sb_miso(sb_miso),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_cfg(wr_cfg)
    );

    xmc_cfg_bank #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_cfg(wr_cfg),
        .rd_addr(sb_addr), .rd_cfg(rd_cfg), .cfg_q(cfg_q)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_line
        xmc_line_ctrl u_line (
            .cfg(cfg_q[c]), .rts(ch_rts[c]),
            .drv_en(ch_drv_en[c]), .rx_en(ch_rx_en[c]),
            .sel_rs485(ch_rs485[c]), .sel_hdx(ch_hdx[c])
        );
    end
endmodule

// File: rtl/xcvr_mode_ctrl_chk.sv
module xcvr_mode_ctrl_chk
    import xcvr_mode_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int ADDR_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sb_miso,
    input logic [N_CH-1:0]      ch_rts,
    input logic [N_CH-1:0]      ch_drv_en,
    input logic [N_CH-1:0]      ch_rx_en,
    input logic [N_CH-1:0]      ch_rs485,
    input logic [N_CH-1:0]      ch_hdx,
    input logic                 wr_stb,
    input logic [ADDR_W-1:0]    wr_addr,
    input chan_cfg_t [N_CH-1:0] cfg_q,
    input frame_st_t            fsm_st
);
    logic [N_CH-1:0] echo_v, std_v, dup_v;
    always_comb begin
        for (int c = 0; c < N_CH; c++) begin
            echo_v[c] = cfg_q[c].echo_inh;
            std_v[c]  = cfg_q[c].rs485;
            dup_v[c]  = cfg_q[c].half_dx;
        end
    end

    a_r7_rs232_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (~ch_rs485 & ~ch_drv_en) == '0);
    a_r7_rs485_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_rs485 & (ch_drv_en ^ ch_rts)) == '0);
    a_r8_echo_block: assert property (@(posedge clk) disable iff (!rst_n)
        (echo_v & ch_rts & ch_rx_en) == '0);
    a_r8_rx_open: assert property (@(posedge clk) disable iff (!rst_n)
        ((~echo_v | ~ch_rts) & ~ch_rx_en) == '0);
    a_r9_mode_pins: assert property (@(posedge clk) disable iff (!rst_n)
        ch_rs485 == std_v && ch_hdx == dup_v);
    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(cfg_q));
    a_r5_unused_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && int'(wr_addr) >= N_CH) |=> $stable(cfg_q));
    a_r3_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_st == ST_IDLE |-> !sb_miso);
endmodule

bind xcvr_mode_ctrl xcvr_mode_ctrl_chk #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sb_miso(sb_miso), .ch_rts(ch_rts),
    .ch_drv_en(ch_drv_en), .ch_rx_en(ch_rx_en), .ch_rs485(ch_rs485),
    .ch_hdx(ch_hdx), .wr_stb(wr_stb), .wr_addr(wr_addr), .cfg_q(cfg_q),
    .fsm_st(u_fsm.st_q)
);

// File: tb/sim_xcvr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_xcvr_mode_ctrl;
    localparam int HALF = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sb_cs_n = 1'b1, sb_rd = 1'b0, sb_sck = 1'b0, sb_mosi = 1'b0;
    logic [2:0] sb_addr = '0;
    logic       sb_miso;
    logic [3:0] ch_rts = '0;
    logic [3:0] ch_drv_en, ch_rx_en, ch_rs485, ch_hdx;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    xcvr_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sb_cs_n(sb_cs_n), .sb_rd(sb_rd),
        .sb_sck(sb_sck), .sb_addr(sb_addr), .sb_mosi(sb_mosi),
        .sb_miso(sb_miso), .ch_rts(ch_rts), .ch_drv_en(ch_drv_en),
        .ch_rx_en(ch_rx_en), .ch_rs485(ch_rs485), .ch_hdx(ch_hdx)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // host serial master: nbits rising edges, MSB first; extra bits send 1
    task automatic xfer(input logic rd, input logic [2:0] a, input logic [7:0] wd,
                        input int nbits, output logic [7:0] rv);
        rv = '0;
        @(negedge clk);
        sb_addr = a; sb_rd = rd; sb_cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            sb_sck  = 1'b0;
            sb_mosi = (i < 8) ? wd[7-i] : 1'b1;
            wait_clk(HALF);
            if (i < 8) rv[7-i] = sb_miso;
            sb_sck = 1'b1;
            wait_clk(HALF);
        end
        sb_sck = 1'b0;
        wait_clk(HALF);
        sb_cs_n = 1'b1;
        wait_clk(2*HALF);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] dummy;
        xfer(1'b0, a, d, 8, dummy);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        xfer(1'b1, a, 8'h00, 8, d);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check(ch_drv_en == 4'hF && ch_rx_en == 4'hF, "R1 drv/rx", {ch_drv_en, ch_rx_en}, 8'hFF);
        check(ch_rs485 == 4'h0 && ch_hdx == 4'h0, "R1 mode pins", {ch_rs485, ch_hdx}, 0);
        check(sb_miso == 1'b0, "R1 miso idle", sb_miso, 0);
        for (int c = 0; c < 4; c++) begin
            rd(3'(c), v);
            check(v == 8'h00, "R1 reg reset", v, 0);
        end
    endtask

    task automatic t_write_read;
        logic [7:0] v;
        logic [2:0] exp [4] = '{3'b001, 3'b010, 3'b100, 3'b111};
        for (int c = 0; c < 4; c++) wr(3'(c), 8'(exp[c]));
        for (int c = 0; c < 4; c++) begin
            rd(3'(c), v);
            check(v == 8'(exp[c]), "R2 R3 R10 readback", v, exp[c]);
            check(ch_rs485[c] == exp[c][0] && ch_hdx[c] == exp[c][1], "R9 mode pins",
                  {ch_hdx[c], ch_rs485[c]}, exp[c][1:0]);
        end
    endtask

    task automatic t_upper_bits;
        logic [7:0] v;
        wr(3'd3, 8'hF9);
        rd(3'd3, v);
        check(v == 8'h01, "R6 upper bits dropped", v, 8'h01);
    endtask

    task automatic t_truncated;
        logic [7:0] v, dummy;
        xfer(1'b0, 3'd1, 8'h05, 5, dummy);
        rd(3'd1, v);
        check(v == 8'h02, "R4 short write discarded", v, 8'h02);
        check(ch_hdx[1] == 1'b1 && ch_rs485[1] == 1'b0, "R4 pins kept", {ch_hdx[1], ch_rs485[1]}, 2);
    endtask

    task automatic t_unused_addr;
        logic [7:0] v;
        logic [2:0] exp [4] = '{3'b001, 3'b010, 3'b100, 3'b001};
        wr(3'd5, 8'hFF);
        for (int c = 0; c < 4; c++) begin
            rd(3'(c), v);
            check(v == 8'(exp[c]), "R5 unused write ignored", v, exp[c]);
        end
        rd(3'd6, v);
        check(v == 8'h00, "R5 read addr 6", v, 0);
        rd(3'd4, v);
        check(v == 8'h00, "R5 read addr 4", v, 0);
    endtask

    task automatic t_extra_clocks;
        logic [7:0] v, dummy;
        xfer(1'b0, 3'd0, 8'h06, 10, dummy);
        rd(3'd0, v);
        check(v == 8'h06, "R11 extra clocks ignored", v, 8'h06);
        rd(3'd1, v);
        check(v == 8'h02, "R10 neighbour kept", v, 8'h02);
    endtask

    task automatic t_line_modes;
        for (int m = 0; m < 8; m++) begin
            wr(3'd2, 8'(m));
            for (int r = 0; r < 2; r++) begin
                @(negedge clk);
                ch_rts[2] = r[0];
                wait_clk(1);
                check(ch_drv_en[2] == (m[0] ? r[0] : 1'b1), "R7 driver enable",
                      ch_drv_en[2], m[0] ? r : 1);
                check(ch_rx_en[2] == ~(m[2] & r[0]), "R8 receiver enable",
                      ch_rx_en[2], ~(m[2] & r[0]));
                check(ch_rs485[2] == m[0] && ch_hdx[2] == m[1], "R9 mode pins",
                      {ch_hdx[2], ch_rs485[2]}, m[1:0]);
            end
            ch_rts[2] = 1'b0;
        end
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_write_read();
        t_upper_bits();
        t_truncated();
        t_unused_addr();
        t_extra_clocks();
        t_line_modes();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule